// File: doc/BRIEF.md
# Dual-Bus 8-Bit Processor Datapath

This block is the register-and-arithmetic core of a multicycle 8-bit processor with a 16-bit address space. It holds these registers:

- a program counter kept as a low byte and a high byte;
- a status byte;
- a four-entry register file: accumulator, two index registers and stack pointer;
- a pair of scratch bytes (low and high) that a multi-state instruction uses to assemble an effective address.

A sequencer outside the block drives a control word every cycle. The word picks one source for each of two operand buses and one ALU function. It also chooses which registers capture the ALU result on the next rising edge.

The ALU result is always visible on the write-data output. The address output shows either the program counter or the scratch pair. The program counter can also step by one across its full 16 bits. Decimal arithmetic is not supported.

Top module: `cpu8_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared to zero: program counter, scratch bytes, status byte and all four register-file entries.
- R2: The register-file entries are indexed 0 = accumulator, 1 = X, 2 = Y, 3 = stack pointer. When `rf_we` is high, entry `rf_dst` takes the ALU result; the entry selected by `a_reg` is readable on bus A.
- R3: `tl_we` and `th_we` load the low and high scratch bytes from the ALU result. `addr` is `{pc_h, pc_l}` when `addr_sel` is 0 and `{scratch_h, scratch_l}` when it is 1.
- R4: Bus A source codes on `a_sel`: 0 = `const_in`, 1 = `mem_rdata`, 2 = scratch low, 3 = scratch high, 4 = register-file entry `a_reg`. Codes 5 to 7 give zero.
- R5: Bus B source codes on `b_sel`: 0 = PC low, 1 = PC high, 2 = scratch low, 3 = scratch high, 4 = status byte, 5 = `mem_rdata`. Codes 6 and 7 give zero.
- R6: `alu_op` 1 is add A+B+C and 2 is subtract A-B-(1-C). Both set C from the carry out (1 = no borrow for subtract) and set V on signed overflow.
- R7: `alu_op` 0 passes A, 3 is AND, 4 is OR and 5 is XOR. These leave C and V as they were. Codes 12 to 15 behave like 0.
- R8: `alu_op` 6 shifts left with 0 in, 7 rotates left through C, 8 shifts right with 0 in, and 9 rotates right through C. In each case C receives the bit shifted out and V is kept.
- R9: `alu_op` 10 adds one to A and 11 subtracts one from A, with wrap-around; C and V are kept.
- R10: The status byte holds N at bit 7, V at bit 6, Z at bit 1 and C at bit 0, with the other bits zero. Z and N follow the ALU result. The byte changes only on an edge where `flags_we` is high.
- R11: When `pc_inc` is high and neither PC byte is being written, the 16-bit program counter steps by one. The low byte carries into the high byte, and 0xFFFF wraps to 0x0000. With no PC control active, the counter holds.
- R12: When `pcl_we` or `pch_we` is high, the selected PC byte(s) take the ALU result and `pc_inc` is ignored for that cycle.
- R13: `wdata` is the current ALU result. A register read in the same cycle in which it is written returns its old value, and the new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_sel | input | 3 | Bus A source code |
| a_reg | input | 2 | Register-file entry read onto bus A |
| b_sel | input | 3 | Bus B source code |
| alu_op | input | 4 | ALU function code |
| rf_we | input | 1 | Register-file write enable |
| rf_dst | input | 2 | Register-file entry written |
| pcl_we | input | 1 | PC low byte load |
| pch_we | input | 1 | PC high byte load |
| tl_we | input | 1 | Scratch low byte load |
| th_we | input | 1 | Scratch high byte load |
| flags_we | input | 1 | Status byte update enable |
| pc_inc | input | 1 | 16-bit PC step |
| addr_sel | input | 1 | Address source: 0 PC, 1 scratch pair |
| mem_rdata | input | 8 | Memory read data |
| const_in | input | 8 | Constant from the sequencer |
| addr | output | 16 | Memory address |
| wdata | output | 8 | ALU result / memory write data |

## Verification
The hardest situations to reach are those where the carry flag left by one operation must feed a later one. Examples are add-with-carry after a wrap, subtract with a pending borrow, rotates through C, and an increment that must leave a previously set C alone. Each of these is reached from the ports by a chain of flag-writing operations. The chain is arranged so that each step starts from a known status byte, and the byte is read back through bus B into an OR with a zero constant. The PC carry ripple is reached by loading 0x12FF and 0xFFFF into the two PC bytes through the ALU before stepping.

// File: rtl/dp_pkg.sv
package dp_pkg;
    localparam int DW       = 8;
    localparam int AW       = 2 * DW;
    localparam int RF_N     = 4;
    localparam int RF_IW    = $clog2(RF_N);
    localparam int SEL_W    = 3;
    localparam int OP_W     = 4;

    typedef enum logic [SEL_W-1:0] {
        A_CONST = 3'd0, A_MEM = 3'd1, A_TL = 3'd2, A_TH = 3'd3, A_RF = 3'd4
    } asel_e;

    typedef enum logic [SEL_W-1:0] {
        B_PCL = 3'd0, B_PCH = 3'd1, B_TL = 3'd2, B_TH = 3'd3,
        B_STAT = 3'd4, B_MEM = 3'd5
    } bsel_e;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 4'd0, OP_ADC = 4'd1, OP_SBC = 4'd2, OP_AND = 4'd3,
        OP_OR   = 4'd4, OP_XOR = 4'd5, OP_SHL = 4'd6, OP_ROL = 4'd7,
        OP_SHR  = 4'd8, OP_ROR = 4'd9, OP_INC = 4'd10, OP_DEC = 4'd11
    } aluop_e;

    typedef struct packed {
        logic       n;
        logic       v;
        logic [3:0] rsv;
        logic       z;
        logic       c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] y;
        logic          c;
        logic          v;
        logic          z;
        logic          n;
    } alu_res_t;

    function automatic flags_t flags_from(input alu_res_t r);
        flags_t f;
        f.n   = r.n;
        f.v   = r.v;
        f.rsv = '0;
        f.z   = r.z;
        f.c   = r.c;
        return f;
    endfunction
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile
    import dp_pkg::*;
#(
    parameter int N = RF_N,
    parameter int W = DW,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] wsel,
    input  logic [W-1:0]  wd,
    input  logic [IW-1:0] rsel,
    output logic [W-1:0]  rd
);
    logic [W-1:0] mem [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (we && wsel == IW'(i))
                mem[i] <= wd;
        end
    end

    assign rd = mem[rsel];
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int W = DW
) (
    input  aluop_e        op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic          c_in,
    input  logic          v_in,
    output alu_res_t      res
);
    logic [W:0] sum;

    always_comb begin
        sum   = '0;
        res.y = a;
        res.c = c_in;
        res.v = v_in;
        unique case (op)
            OP_ADC: begin
                sum   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c_in};
                res.y = sum[W-1:0];
                res.c = sum[W];
                res.v = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
            end
            OP_SBC: begin
                sum   = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, c_in};
                res.y = sum[W-1:0];
                res.c = sum[W];
                res.v = (a[W-1] != b[W-1]) && (sum[W-1] != a[W-1]);
            end
            OP_AND: res.y = a & b;
            OP_OR:  res.y = a | b;
            OP_XOR: res.y = a ^ b;
            OP_SHL: begin res.y = {a[W-2:0], 1'b0}; res.c = a[W-1]; end
            OP_ROL: begin res.y = {a[W-2:0], c_in}; res.c = a[W-1]; end
            OP_SHR: begin res.y = {1'b0, a[W-1:1]}; res.c = a[0];   end
            OP_ROR: begin res.y = {c_in, a[W-1:1]}; res.c = a[0];   end
            OP_INC: res.y = a + W'(1);
            OP_DEC: res.y = a - W'(1);
            default: res.y = a;
        endcase
        res.z = (res.y == '0);
        res.n = res.y[W-1];
    end
endmodule

// File: rtl/cpu8_datapath.sv
module cpu8_datapath
    import dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  a_sel,
    input  logic [RF_IW-1:0]  a_reg,
    input  logic [SEL_W-1:0]  b_sel,
    input  logic [OP_W-1:0]   alu_op,
    input  logic              rf_we,
    input  logic [RF_IW-1:0]  rf_dst,
    input  logic              pcl_we,
    input  logic              pch_we,
    input  logic              tl_we,
    input  logic              th_we,
    input  logic              flags_we,
    input  logic              pc_inc,
    input  logic              addr_sel,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [DW-1:0]     const_in,
    output logic [AW-1:0]     addr,
    output logic [DW-1:0]     wdata
);
    logic [DW-1:0] pc_l, pc_h, temp_l, temp_h, rf_rd;
    logic [DW-1:0] bus_a, bus_b;
    flags_t        flags_q;
    alu_res_t      alu_res;

    dp_regfile #(.N(RF_N), .W(DW)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .wsel(rf_dst),
        .wd(alu_res.y), .rsel(a_reg), .rd(rf_rd)
    );

    always_comb begin
        unique case (asel_e'(a_sel))
            A_CONST: bus_a = const_in;
            A_MEM:   bus_a = mem_rdata;
            A_TL:    bus_a = temp_l;
            A_TH:    bus_a = temp_h;
            A_RF:    bus_a = rf_rd;
            default: bus_a = '0;
        endcase
    end

    always_comb begin
        unique case (bsel_e'(b_sel))
            B_PCL:   bus_b = pc_l;
            B_PCH:   bus_b = pc_h;
            B_TL:    bus_b = temp_l;
            B_TH:    bus_b = temp_h;
            B_STAT:  bus_b = flags_q;
            B_MEM:   bus_b = mem_rdata;
            default: bus_b = '0;
        endcase
    end

    dp_alu #(.W(DW)) u_alu (
        .op(aluop_e'(alu_op)), .a(bus_a), .b(bus_b),
        .c_in(flags_q.c), .v_in(flags_q.v), .res(alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_l <= '0;
            pc_h <= '0;
        end else if (pcl_we || pch_we) begin
            if (pcl_we) pc_l <= alu_res.y;
            if (pch_we) pc_h <= alu_res.y;
        end else if (pc_inc) begin
            {pc_h, pc_l} <= {pc_h, pc_l} + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_l  <= '0;
            temp_h  <= '0;
            flags_q <= '0;
        end else begin
            if (tl_we)    temp_l  <= alu_res.y;
            if (th_we)    temp_h  <= alu_res.y;
            if (flags_we) flags_q <= flags_from(alu_res);
        end
    end

    assign addr  = addr_sel ? {temp_h, temp_l} : {pc_h, pc_l};
    assign wdata = alu_res.y;
endmodule

module cpu8_datapath_checker
    import dp_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          pc_inc,
    input logic          pcl_we,
    input logic          pch_we,
    input logic          tl_we,
    input logic          flags_we,
    input logic [AW-1:0] pc,
    input logic [DW-1:0] flags,
    input logic [DW-1:0] alu_y,
    input logic [DW-1:0] temp_l
);
    a_r11_pc_step: assert property (@(posedge clk) disable iff (rst)
        (pc_inc && !pcl_we && !pch_we) |=> (pc == $past(pc) + AW'(1)));

    a_r11_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (!pc_inc && !pcl_we && !pch_we) |=> $stable(pc));

    a_r12_pcl_load: assert property (@(posedge clk) disable iff (rst)
        pcl_we |=> (pc[DW-1:0] == $past(alu_y)));

    a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !flags_we |=> $stable(flags));

    a_r10_zero_track: assert property (@(posedge clk) disable iff (rst)
        flags_we |=> (flags[1] == ($past(alu_y) == '0)));

    a_r3_temp_hold: assert property (@(posedge clk) disable iff (rst)
        !tl_we |=> $stable(temp_l));
endmodule

bind cpu8_datapath cpu8_datapath_checker u_chk (
    .clk(clk), .rst(rst), .pc_inc(pc_inc), .pcl_we(pcl_we),
    .pch_we(pch_we), .tl_we(tl_we), .flags_we(flags_we),
    .pc({pc_h, pc_l}), .flags(flags_q), .alu_y(alu_res.y),
    .temp_l(temp_l)
);

// File: tb/cpu8_datapath_test.sv
`timescale 1ns/100ps
module cpu8_datapath_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  a_sel = '0;
    logic [1:0]  a_reg = '0;
    logic [2:0]  b_sel = '0;
    logic [3:0]  alu_op = '0;
    logic        rf_we = 0, pcl_we = 0, pch_we = 0, tl_we = 0, th_we = 0;
    logic        flags_we = 0, pc_inc = 0, addr_sel = 0;
    logic [1:0]  rf_dst = '0;
    logic [7:0]  mem_rdata = '0, const_in = '0;
    logic [15:0] addr;
    logic [7:0]  wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string      req;
        bit         is_addr;
        logic [15:0] exp;
    } item_t;
    item_t sb[$];
    event  sample_ev;

    cpu8_datapath uut (
        .clk(clk), .rst(rst), .a_sel(a_sel), .a_reg(a_reg), .b_sel(b_sel),
        .alu_op(alu_op), .rf_we(rf_we), .rf_dst(rf_dst), .pcl_we(pcl_we),
        .pch_we(pch_we), .tl_we(tl_we), .th_we(th_we), .flags_we(flags_we),
        .pc_inc(pc_inc), .addr_sel(addr_sel), .mem_rdata(mem_rdata),
        .const_in(const_in), .addr(addr), .wdata(wdata)
    );

    always #2 clk = ~clk;

    // monitor: pops expected items and compares with the outputs
    always @(sample_ev) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sb.pop_front();
            act = it.is_addr ? addr : {8'h00, wdata};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic expect_out(string req, bit is_addr, logic [15:0] exp);
        item_t it;
        it.req = req; it.is_addr = is_addr; it.exp = exp;
        sb.push_back(it);
        -> sample_ev;
        #0.2;
    endtask

    task automatic idle();
        a_sel = 3'd0; a_reg = 2'd0; b_sel = 3'd7; alu_op = 4'd0;
        rf_we = 0; rf_dst = 0; pcl_we = 0; pch_we = 0; tl_we = 0; th_we = 0;
        flags_we = 0; pc_inc = 0; addr_sel = 0; const_in = 0; mem_rdata = 0;
    endtask

    task automatic tick();
        @(posedge clk); #0.2; idle(); #0.2;
    endtask

    // drive bus A from constant, B from memory, chosen op
    task automatic op_cm(logic [3:0] op, logic [7:0] a, logic [7:0] b, bit fw);
        idle(); alu_op = op; a_sel = 3'd0; const_in = a;
        b_sel = 3'd5; mem_rdata = b; flags_we = fw; #0.2;
    endtask

    task automatic check_flags(string req, logic [7:0] exp);
        idle(); a_sel = 3'd0; const_in = 8'h00; b_sel = 3'd4; alu_op = 4'd4; #0.2;
        expect_out(req, 0, {8'h00, exp});
    endtask

    task automatic load_rf(logic [1:0] idx, logic [7:0] v);
        idle(); a_sel = 3'd0; const_in = v; rf_we = 1; rf_dst = idx; #0.2;
        tick();
    endtask

    task automatic read_rf(string req, logic [1:0] idx, logic [7:0] exp);
        idle(); a_sel = 3'd4; a_reg = idx; #0.2;
        expect_out(req, 0, {8'h00, exp});
    endtask

    task automatic load_byte(int which, logic [7:0] v);
        idle(); a_sel = 3'd0; const_in = v;
        case (which)
            0: pcl_we = 1;
            1: pch_we = 1;
            2: tl_we = 1;
            default: th_we = 1;
        endcase
        #0.2; tick();
    endtask

    task automatic read_b(string req, logic [2:0] sel, logic [7:0] exp);
        idle(); a_sel = 3'd0; const_in = 8'h00; b_sel = sel; alu_op = 4'd4; #0.2;
        expect_out(req, 0, {8'h00, exp});
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        #0.2; rst = 0; #0.2;

        // R1 reset state
        expect_out("R1 pc", 1, 16'h0000);
        addr_sel = 1; #0.2; expect_out("R1 scratch", 1, 16'h0000);
        check_flags("R1 status", 8'h00);
        for (int i = 0; i < 4; i++) read_rf("R1 regfile", 2'(i), 8'h00);

        // R2 register file
        load_rf(0, 8'hA1); load_rf(1, 8'hB2); load_rf(2, 8'hC3); load_rf(3, 8'hD4);
        read_rf("R2 acc", 0, 8'hA1); read_rf("R2 x", 1, 8'hB2);
        read_rf("R2 y", 2, 8'hC3);   read_rf("R2 sp", 3, 8'hD4);

        // R3 scratch and address select
        load_byte(2, 8'h34); load_byte(3, 8'h12);
        idle(); addr_sel = 1; #0.2; expect_out("R3 addr scratch", 1, 16'h1234);
        idle(); addr_sel = 0; #0.2; expect_out("R3 addr pc", 1, 16'h0000);

        // R4 bus A sources
        idle(); a_sel = 3'd0; const_in = 8'h5A; #0.2; expect_out("R4 const", 0, 16'h005A);
        idle(); a_sel = 3'd1; mem_rdata = 8'h6B; #0.2; expect_out("R4 mem", 0, 16'h006B);
        idle(); a_sel = 3'd2; #0.2; expect_out("R4 scratch lo", 0, 16'h0034);
        idle(); a_sel = 3'd3; #0.2; expect_out("R4 scratch hi", 0, 16'h0012);
        idle(); a_sel = 3'd4; a_reg = 2; #0.2; expect_out("R4 rf", 0, 16'h00C3);
        idle(); a_sel = 3'd6; const_in = 8'hFF; #0.2; expect_out("R4 unused", 0, 16'h0000);

        // R5 bus B sources
        load_byte(0, 8'h9C); load_byte(1, 8'h47);
        read_b("R5 pcl", 3'd0, 8'h9C); read_b("R5 pch", 3'd1, 8'h47);
        read_b("R5 tl", 3'd2, 8'h34);  read_b("R5 th", 3'd3, 8'h12);
        idle(); const_in = 0; b_sel = 3'd5; mem_rdata = 8'h3E; alu_op = 4'd4; #0.2;
        expect_out("R5 mem", 0, 16'h003E);
        read_b("R5 unused", 3'd7, 8'h00);

        // R6 add/subtract chain with flags (R10 layout)
        op_cm(4'd1, 8'h50, 8'h50, 1); expect_out("R6 adc signed ovf", 0, 16'h00A0); tick();
        check_flags("R10 N V after adc", 8'hC0);
        op_cm(4'd1, 8'hFF, 8'h01, 1); expect_out("R6 adc wrap", 0, 16'h0000); tick();
        check_flags("R10 C Z after adc", 8'h03);
        op_cm(4'd1, 8'h10, 8'h20, 0); expect_out("R6 adc carry in", 0, 16'h0031); tick();
        check_flags("R10 hold without enable", 8'h03);
        op_cm(4'd2, 8'h10, 8'h01, 1); expect_out("R6 sbc", 0, 16'h000F); tick();
        check_flags("R6 sbc no borrow", 8'h01);
        op_cm(4'd2, 8'h80, 8'h01, 1); expect_out("R6 sbc ovf", 0, 16'h007F); tick();
        check_flags("R6 sbc V", 8'h41);
        op_cm(4'd2, 8'h00, 8'h01, 1); expect_out("R6 sbc borrow", 0, 16'h00FF); tick();
        check_flags("R6 sbc borrow flags", 8'h80);
        op_cm(4'd2, 8'h05, 8'h02, 0); expect_out("R6 sbc borrow in", 0, 16'h0002);

        // R7 logic ops
        op_cm(4'd3, 8'hF0, 8'h3C, 0); expect_out("R7 and", 0, 16'h0030);
        op_cm(4'd4, 8'hF0, 8'h3C, 0); expect_out("R7 or", 0, 16'h00FC);
        op_cm(4'd5, 8'hF0, 8'h3C, 0); expect_out("R7 xor", 0, 16'h00CC);
        op_cm(4'd13, 8'h77, 8'h3C, 0); expect_out("R7 spare code", 0, 16'h0077);
        op_cm(4'd5, 8'h0F, 8'h0F, 1); expect_out("R7 xor zero", 0, 16'h0000); tick();
        check_flags("R7 logic keeps C V", 8'h02);

        // R8 shifts and rotates
        op_cm(4'd6, 8'h81, 8'h00, 1); expect_out("R8 shl", 0, 16'h0002); tick();
        check_flags("R8 shl carry out", 8'h01);
        op_cm(4'd7, 8'h40, 8'h00, 1); expect_out("R8 rol", 0, 16'h0081); tick();
        check_flags("R8 rol flags", 8'h80);
        op_cm(4'd8, 8'h01, 8'h00, 1); expect_out("R8 shr", 0, 16'h0000); tick();
        check_flags("R8 shr flags", 8'h03);
        op_cm(4'd9, 8'h02, 8'h00, 1); expect_out("R8 ror", 0, 16'h0081); tick();
        check_flags("R8 ror flags", 8'h80);

        // R9 increment/decrement
        op_cm(4'd10, 8'hFF, 8'h00, 1); expect_out("R9 inc wrap", 0, 16'h0000); tick();
        check_flags("R9 inc flags", 8'h02);
        op_cm(4'd11, 8'h00, 8'h00, 1); expect_out("R9 dec wrap", 0, 16'h00FF); tick();
        check_flags("R9 dec flags", 8'h80);
        op_cm(4'd8, 8'h01, 8'h00, 1); tick();
        op_cm(4'd10, 8'h7F, 8'h00, 1); expect_out("R9 inc", 0, 16'h0080); tick();
        check_flags("R9 inc keeps C", 8'h81);

        // R11 program counter stepping
        load_byte(0, 8'hFF); load_byte(1, 8'h12);
        idle(); #0.2; expect_out("R11 loaded", 1, 16'h12FF);
        idle(); pc_inc = 1; #0.2; tick();
        expect_out("R11 carry ripple", 1, 16'h1300);
        tick(); expect_out("R11 hold", 1, 16'h1300);
        load_byte(0, 8'hFF); load_byte(1, 8'hFF);
        idle(); pc_inc = 1; #0.2; tick();
        expect_out("R11 wrap", 1, 16'h0000);

        // R12 load beats increment
        load_byte(1, 8'h13);
        idle(); a_sel = 0; const_in = 8'h55; pcl_we = 1; pc_inc = 1; #0.2; tick();
        expect_out("R12 low load over step", 1, 16'h1355);
        idle(); a_sel = 0; const_in = 8'h21; pch_we = 1; pc_inc = 1; #0.2; tick();
        expect_out("R12 high load over step", 1, 16'h2155);

        // R13 same-cycle read returns old value
        load_rf(0, 8'h11);
        idle(); a_sel = 3'd4; a_reg = 0; alu_op = 4'd10; rf_we = 1; rf_dst = 0; #0.2;
        expect_out("R13 old value during write", 0, 16'h0012);
        @(posedge clk); #0.2;
        expect_out("R13 result follows new value", 0, 16'h0013);
        idle(); #0.2;
        read_rf("R13 new value", 0, 8'h12);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule